// File: doc/BRIEF.md
# Fixed-Layout I/O Register Header Decoder

This block serves a transitional paravirtual device that still has to answer drivers written for the older fixed I/O register header. Each access carries a byte offset, a width and, for writes, right-aligned data. The block decodes the offset into one header field, keeps the small per-device registers (acknowledged feature word, queue selector, status byte, interrupt cause byte, configuration vector), and hands per-queue items to storage held outside. That storage is the queue page address, the queue size and the queue vector, and it is indexed by the selector that the block drives.

Two header words exist only while MSI-X is on. The device-specific area therefore starts at byte 20 with MSI-X off and at byte 24 with it on. The boundary follows the enable input cycle by cycle. Accesses at or above the boundary are passed to a device-specific port as an offset relative to the start of that area. The block also pulses a queue notification, and it raises a flag when a driver completes setup without acknowledging the modern-revision feature bit.

Top module: `lgh_io_header`

## Requirements
- R1: After synchronous reset, rd_valid, notify_valid, qaddr_wr, qvec_wr, legacy_drv, q_sel, dev_status and drv_feat are all zero.
- R2: A 32-bit read at offset 0 returns dev_feat[31:0]. drv_feat[63:32] always reads zero, so feature bits 32 to 63 are never acknowledged through this header.
- R3: A 32-bit write at offset 4 sets drv_feat[31:0], and a 32-bit read at offset 4 returns that value.
- R4: A 32-bit write at offset 8 holds a page number. In the next cycle qaddr_wr pulses and qaddr_byte equals that number shifted left by 12. A read at offset 8 returns qaddr_rd shifted right by 12.
- R5: A 16-bit read at offset 12 returns qsize_rd. A 16-bit write at offset 14 sets q_sel, and a read there returns it. Each read result appears on rd_data with rd_valid exactly one cycle after the access.
- R6: A 16-bit write at offset 16 gives a one-cycle notify_valid pulse in the next cycle, with notify_qidx equal to the written index.
- R7: An 8-bit write at offset 18 sets dev_status, and an 8-bit read there returns it.
- R8: An 8-bit read at offset 19 returns the pending interrupt bits and clears them. A bit that isr_set raises in the same cycle as the read stays pending.
- R9: With msix_en high, offset 20 (16-bit) is the read/write configuration vector. Offset 22 (16-bit) is the queue vector: a write pulses qvec_wr with qvec_wdata next cycle, and a read returns qvec_rd. The device-specific area starts at 24. With msix_en low it starts at 20, and the switch follows msix_en in both directions.
- R10: Accesses at or above the device-specific boundary assert dev_valid in the same cycle, with dev_off equal to the address minus the boundary and with the width passed through. Read data is dev_rdata masked to the access width (byte 0xFF, half 0xFFFF, word all ones; size codes 0, 1 and 2).
- R11: A header access whose width is not the field's natural width, or that does not start at a field, is void: a write changes nothing and a read returns 0.
- R12: legacy_drv is set when an offset-18 write sets status bit 2 (value 0x04) while feat32_acked is low. It stays clear if feat32_acked is high. A status write of 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msix_en | input | 1 | MSI-X enabled; moves the device-specific boundary |
| feat32_acked | input | 1 | Modern-revision feature bit acknowledged elsewhere |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | ADDR_W | Byte offset into the header |
| acc_size | input | 2 | 0 byte, 1 half, 2 word |
| acc_wdata | input | 32 | Right-aligned write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| dev_feat | input | 64 | Features offered by the device |
| drv_feat | output | 64 | Features acknowledged via this header |
| q_sel | output | 16 | Selected queue |
| qsize_rd | input | 16 | Size of the selected queue |
| qaddr_rd | input | 44 | Byte address of the selected ring |
| qaddr_wr | output | 1 | Ring address write strobe |
| qaddr_byte | output | 44 | Ring byte address to store |
| qvec_rd | input | 16 | Vector of the selected queue |
| qvec_wr | output | 1 | Queue vector write strobe |
| qvec_wdata | output | 16 | Queue vector to store |
| notify_valid | output | 1 | Queue notification pulse |
| notify_qidx | output | 16 | Notified queue index |
| dev_status | output | 8 | Device status byte |
| isr_set | input | 8 | Interrupt cause bits to raise |
| legacy_drv | output | 1 | Legacy driver detected |
| dev_valid | output | 1 | Device-specific access |
| dev_write | output | 1 | Device-specific write |
| dev_off | output | ADDR_W | Offset in device-specific area |
| dev_size | output | 2 | Access width passed through |
| dev_wdata | output | 32 | Device-specific write data |
| dev_rdata | input | 32 | Device-specific read data |

## Verification
The main same-cycle conflict is a read of the interrupt cause byte in the very cycle in which a new cause arrives on isr_set. The bench first raises one cause and then reads offset 19 while it pulses a different cause. The read must return only the older bit, and a following read must still show the newer one. The second conflict is a change of msix_en between accesses: the same offset 20 must be judged as the configuration vector in one cycle and as device-specific data in another, with the expected values taken from the boundary rule.

// File: rtl/lgh_pkg.sv
package lgh_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        F_BAD,
        F_DEVFEAT,
        F_DRVFEAT,
        F_QADDR,
        F_QSIZE,
        F_QSEL,
        F_NOTIFY,
        F_STATUS,
        F_ISR,
        F_CFGVEC,
        F_QVEC,
        F_DEVSPEC
    } field_e;

    // byte offsets inside the fixed header; drivers depend on them
    localparam int OFS_DEVFEAT = 0;
    localparam int OFS_DRVFEAT = 4;
    localparam int OFS_QADDR   = 8;
    localparam int OFS_QSIZE   = 12;
    localparam int OFS_QSEL    = 14;
    localparam int OFS_NOTIFY  = 16;
    localparam int OFS_STATUS  = 18;
    localparam int OFS_ISR     = 19;
    localparam int OFS_CFGVEC  = 20;
    localparam int OFS_QVEC    = 22;
    localparam int HDR_BYTES   = 20;
    localparam int VEC_BYTES   = 4;

    localparam int QIDX_W = 16;
    localparam logic [7:0] STAT_DRIVER_OK = 8'h04;

    typedef struct packed {
        logic        wr;
        logic        rd;
        field_e      field;
        logic [31:0] wdata;
    } hdr_op_t;

    function automatic logic [31:0] width_mask(acc_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/lgh_decode.sv
module lgh_decode
    import lgh_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic              msix_en,
    output field_e            field,
    output logic [ADDR_W-1:0] dev_off
);

    localparam int SHORT_START = HDR_BYTES;
    localparam int LONG_START  = HDR_BYTES + VEC_BYTES;

    logic [ADDR_W-1:0] region_start;
    field_e            nominal;
    acc_size_e         need;

    always_comb begin
        region_start = msix_en ? ADDR_W'(LONG_START) : ADDR_W'(SHORT_START);
        nominal      = F_BAD;
        need         = SZ_WORD;
        dev_off      = '0;
        if (addr >= region_start) begin
            nominal = F_DEVSPEC;
            dev_off = addr - region_start;
        end else begin
            case (addr)
                ADDR_W'(OFS_DEVFEAT): begin nominal = F_DEVFEAT; need = SZ_WORD; end
                ADDR_W'(OFS_DRVFEAT): begin nominal = F_DRVFEAT; need = SZ_WORD; end
                ADDR_W'(OFS_QADDR):   begin nominal = F_QADDR;   need = SZ_WORD; end
                ADDR_W'(OFS_QSIZE):   begin nominal = F_QSIZE;   need = SZ_HALF; end
                ADDR_W'(OFS_QSEL):    begin nominal = F_QSEL;    need = SZ_HALF; end
                ADDR_W'(OFS_NOTIFY):  begin nominal = F_NOTIFY;  need = SZ_HALF; end
                ADDR_W'(OFS_STATUS):  begin nominal = F_STATUS;  need = SZ_BYTE; end
                ADDR_W'(OFS_ISR):     begin nominal = F_ISR;     need = SZ_BYTE; end
                ADDR_W'(OFS_CFGVEC):  begin nominal = F_CFGVEC;  need = SZ_HALF; end
                ADDR_W'(OFS_QVEC):    begin nominal = F_QVEC;    need = SZ_HALF; end
                default:              begin nominal = F_BAD;     need = SZ_WORD; end
            endcase
        end
        field = nominal;
        if (nominal != F_DEVSPEC && nominal != F_BAD && size != need)
            field = F_BAD;
    end

endmodule

// File: rtl/lgh_regs.sv
module lgh_regs
    import lgh_pkg::*;
#(
    parameter  int PAGE_SHIFT = 12,
    localparam int QADDR_W    = 32 + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  hdr_op_t            op,
    input  logic [7:0]         isr_set,
    input  logic               feat32_acked,
    output logic [31:0]        drv_feat_lo,
    output logic [QIDX_W-1:0]  q_sel,
    output logic [7:0]         status,
    output logic [15:0]        cfg_vec,
    output logic [7:0]         isr,
    output logic               legacy_drv,
    output logic               notify_valid,
    output logic [QIDX_W-1:0]  notify_qidx,
    output logic               qaddr_wr,
    output logic [QADDR_W-1:0] qaddr_byte,
    output logic               qvec_wr,
    output logic [15:0]        qvec_wdata
);

    logic       wr_drvfeat, wr_qaddr, wr_qsel, wr_notify, wr_status, wr_cfgvec, wr_qvec;
    logic       rd_isr;
    logic [7:0] isr_taken;

    always_comb begin
        wr_drvfeat = op.wr && op.field == F_DRVFEAT;
        wr_qaddr   = op.wr && op.field == F_QADDR;
        wr_qsel    = op.wr && op.field == F_QSEL;
        wr_notify  = op.wr && op.field == F_NOTIFY;
        wr_status  = op.wr && op.field == F_STATUS;
        wr_cfgvec  = op.wr && op.field == F_CFGVEC;
        wr_qvec    = op.wr && op.field == F_QVEC;
        rd_isr     = op.rd && op.field == F_ISR;
        isr_taken  = rd_isr ? isr : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_feat_lo  <= '0;
            q_sel        <= '0;
            status       <= '0;
            cfg_vec      <= '0;
            isr          <= '0;
            legacy_drv   <= 1'b0;
            notify_valid <= 1'b0;
            notify_qidx  <= '0;
            qaddr_wr     <= 1'b0;
            qaddr_byte   <= '0;
            qvec_wr      <= 1'b0;
            qvec_wdata   <= '0;
        end else begin
            notify_valid <= wr_notify;
            qaddr_wr     <= wr_qaddr;
            qvec_wr      <= wr_qvec;
            if (wr_notify)  notify_qidx <= op.wdata[QIDX_W-1:0];
            if (wr_qaddr)   qaddr_byte  <= {op.wdata, {PAGE_SHIFT{1'b0}}};
            if (wr_qvec)    qvec_wdata  <= op.wdata[15:0];
            if (wr_drvfeat) drv_feat_lo <= op.wdata;
            if (wr_qsel)    q_sel       <= op.wdata[QIDX_W-1:0];
            if (wr_cfgvec)  cfg_vec     <= op.wdata[15:0];
            if (wr_status) begin
                status <= op.wdata[7:0];
                if (op.wdata[7:0] == 8'h00)
                    legacy_drv <= 1'b0;
                else if ((op.wdata[7:0] & STAT_DRIVER_OK) != 8'h00 && !feat32_acked)
                    legacy_drv <= 1'b1;
            end
            isr <= (isr & ~isr_taken) | isr_set;
        end
    end

    AST_ISR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_isr && isr_set == 8'h00) |=> isr == 8'h00); // R8

    AST_ISR_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
        (isr_set != 8'h00) |=> (isr & $past(isr_set)) == $past(isr_set)); // R8

    AST_LEGACY_SETS: assert property (@(posedge clk) disable iff (rst)
        (wr_status && op.wdata[2] && !feat32_acked) |=> legacy_drv); // R12

    AST_LEGACY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_status && op.wdata[7:0] == 8'h00) |=> !legacy_drv); // R12

endmodule

// File: rtl/lgh_io_header.sv
module lgh_io_header
    import lgh_pkg::*;
#(
    parameter  int ADDR_W     = 8,
    parameter  int PAGE_SHIFT = 12,
    localparam int QADDR_W    = 32 + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               msix_en,
    input  logic               feat32_acked,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [1:0]         acc_size,
    input  logic [31:0]        acc_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    input  logic [63:0]        dev_feat,
    output logic [63:0]        drv_feat,
    output logic [15:0]        q_sel,
    input  logic [15:0]        qsize_rd,
    input  logic [QADDR_W-1:0] qaddr_rd,
    output logic               qaddr_wr,
    output logic [QADDR_W-1:0] qaddr_byte,
    input  logic [15:0]        qvec_rd,
    output logic               qvec_wr,
    output logic [15:0]        qvec_wdata,
    output logic               notify_valid,
    output logic [15:0]        notify_qidx,
    output logic [7:0]         dev_status,
    input  logic [7:0]         isr_set,
    output logic               legacy_drv,
    output logic               dev_valid,
    output logic               dev_write,
    output logic [ADDR_W-1:0]  dev_off,
    output logic [1:0]         dev_size,
    output logic [31:0]        dev_wdata,
    input  logic [31:0]        dev_rdata
);

    acc_size_e   size_e;
    field_e      field;
    hdr_op_t     op;
    logic [31:0] drv_feat_lo;
    logic [15:0] cfg_vec;
    logic [7:0]  isr;
    logic [31:0] rd_next;

    assign size_e = acc_size_e'(acc_size);

    lgh_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (acc_addr),
        .size    (size_e),
        .msix_en (msix_en),
        .field   (field),
        .dev_off (dev_off)
    );

    always_comb begin
        op.wr    = acc_valid && acc_write;
        op.rd    = acc_valid && !acc_write;
        op.field = field;
        op.wdata = acc_wdata;
    end

    lgh_regs #(.PAGE_SHIFT(PAGE_SHIFT)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .op           (op),
        .isr_set      (isr_set),
        .feat32_acked (feat32_acked),
        .drv_feat_lo  (drv_feat_lo),
        .q_sel        (q_sel),
        .status       (dev_status),
        .cfg_vec      (cfg_vec),
        .isr          (isr),
        .legacy_drv   (legacy_drv),
        .notify_valid (notify_valid),
        .notify_qidx  (notify_qidx),
        .qaddr_wr     (qaddr_wr),
        .qaddr_byte   (qaddr_byte),
        .qvec_wr      (qvec_wr),
        .qvec_wdata   (qvec_wdata)
    );

    // high feature word is never reachable here: always unacknowledged
    assign drv_feat = {32'h0, drv_feat_lo};

    always_comb begin
        dev_valid = acc_valid && field == F_DEVSPEC;
        dev_write = acc_write;
        dev_size  = acc_size;
        dev_wdata = acc_wdata;
    end

    always_comb begin
        case (field)
            F_DEVFEAT: rd_next = dev_feat[31:0];
            F_DRVFEAT: rd_next = drv_feat_lo;
            F_QADDR:   rd_next = qaddr_rd[QADDR_W-1:PAGE_SHIFT];
            F_QSIZE:   rd_next = {16'h0, qsize_rd};
            F_QSEL:    rd_next = {16'h0, q_sel};
            F_STATUS:  rd_next = {24'h0, dev_status};
            F_ISR:     rd_next = {24'h0, isr};
            F_CFGVEC:  rd_next = {16'h0, cfg_vec};
            F_QVEC:    rd_next = {16'h0, qvec_rd};
            F_DEVSPEC: rd_next = dev_rdata & width_mask(size_e);
            default:   rd_next = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            rd_data  <= (acc_valid && !acc_write) ? rd_next : 32'h0;
        end
    end

    AST_DEV_ABOVE_HDR: assert property (@(posedge clk) disable iff (rst)
        dev_valid |-> acc_addr >= (msix_en ? ADDR_W'(HDR_BYTES + VEC_BYTES) : ADDR_W'(HDR_BYTES))); // R9

    AST_NOTIFY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        notify_valid |-> $past(acc_valid && acc_write && acc_addr == ADDR_W'(OFS_NOTIFY))); // R6

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(acc_valid && !acc_write)); // R5

    AST_BAD_WIDTH_FEAT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr == ADDR_W'(OFS_DRVFEAT) && acc_size != 2'd2)
        |=> $stable(drv_feat)); // R11

endmodule

// File: tb/test_lgh_io_header.sv
module test_lgh_io_header;

    localparam int ADDR_W  = 8;
    localparam int QADDR_W = 44;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               msix_en = 1'b0;
    logic               feat32_acked = 1'b0;
    logic               acc_valid = 1'b0;
    logic               acc_write = 1'b0;
    logic [ADDR_W-1:0]  acc_addr = '0;
    logic [1:0]         acc_size = 2'd0;
    logic [31:0]        acc_wdata = '0;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic [63:0]        dev_feat = 64'h0000_0001_8000_0021;
    logic [63:0]        drv_feat;
    logic [15:0]        q_sel;
    logic [15:0]        qsize_rd = 16'h0100;
    logic [QADDR_W-1:0] qaddr_rd = 44'h123_4567_8000;
    logic               qaddr_wr;
    logic [QADDR_W-1:0] qaddr_byte;
    logic [15:0]        qvec_rd = 16'h0042;
    logic               qvec_wr;
    logic [15:0]        qvec_wdata;
    logic               notify_valid;
    logic [15:0]        notify_qidx;
    logic [7:0]         dev_status;
    logic [7:0]         isr_set = 8'h00;
    logic               legacy_drv;
    logic               dev_valid;
    logic               dev_write;
    logic [ADDR_W-1:0]  dev_off;
    logic [1:0]         dev_size;
    logic [31:0]        dev_wdata;
    logic [31:0]        dev_rdata;

    // device-specific area model: result depends on the offset
    assign dev_rdata = {8'h5A, 8'h3C, dev_off, ~dev_off};

    always #10 clk = ~clk;

    lgh_io_header i_lgh_io_header (.*);

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic        done   = 1'b0;
    logic [31:0] exp_q[$];
    string       req_q[$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input int addr, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp,
                       input string req, input logic [7:0] isr_p = 8'h00);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = w;
        acc_addr  = addr[ADDR_W-1:0];
        acc_size  = sz;
        acc_wdata = wd;
        isr_set   = isr_p;
        if (!w) begin
            exp_q.push_back(exp);
            req_q.push_back(req);
        end
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        isr_set   = 8'h00;
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected read", {32'h0, rd_data}, 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       r = req_q.pop_front();
                check(r, {32'h0, rd_data}, {32'h0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_valid", rd_valid, 0);
        check("R1 legacy_drv", legacy_drv, 0);
        check("R1 drv_feat", drv_feat, 0);
        check("R1 q_sel", q_sel, 0);
        check("R1 dev_status", dev_status, 0);
        check("R1 strobes", {notify_valid, qaddr_wr, qvec_wr}, 0);

        // R2 device features, low word only
        acc(0, 0, 2'd2, 0, 32'h8000_0021, "R2 dev_feat read");
        // R3 driver features
        acc(1, 4, 2'd2, 32'hFFFF_FFFF, 0, "R3 write");
        acc(0, 4, 2'd2, 0, 32'hFFFF_FFFF, "R3 drv_feat read");
        check("R2 drv_feat high word zero", drv_feat, 64'h0000_0000_FFFF_FFFF);
        // R11 wrong width / misaligned
        acc(1, 4, 2'd1, 32'h0000_1234, 0, "R11 write");
        acc(0, 4, 2'd2, 0, 32'hFFFF_FFFF, "R11 half write ignored");
        acc(0, 5, 2'd0, 0, 32'h0, "R11 misaligned read zero");
        acc(0, 0, 2'd1, 0, 32'h0, "R11 half read of word field zero");

        // R4 queue page address
        acc(1, 8, 2'd2, 32'h000A_BCDE, 0, "R4 write");
        check("R4 qaddr_wr", qaddr_wr, 1);
        check("R4 qaddr_byte", qaddr_byte, 44'h0_ABCD_E000);
        acc(0, 8, 2'd2, 0, 32'h1234_5678, "R4 page read");

        // R5 queue size and select
        acc(0, 12, 2'd1, 0, 32'h0000_0100, "R5 qsize read");
        acc(1, 14, 2'd1, 32'h0000_0003, 0, "R5 write");
        check("R5 q_sel", q_sel, 3);
        acc(0, 14, 2'd1, 0, 32'h0000_0003, "R5 qsel read");

        // R6 notify
        acc(1, 16, 2'd1, 32'h0000_0005, 0, "R6 write");
        check("R6 notify_valid", notify_valid, 1);
        check("R6 notify_qidx", notify_qidx, 5);
        @(negedge clk);
        check("R6 notify one cycle", notify_valid, 0);

        // R7 status
        acc(1, 18, 2'd0, 32'h0000_0003, 0, "R7 write");
        acc(0, 18, 2'd0, 0, 32'h0000_0003, "R7 status read");
        check("R12 no flag without DRIVER_OK", legacy_drv, 0);

        // R8 interrupt cause, read collides with a new cause
        @(negedge clk); isr_set = 8'h02;
        @(negedge clk); isr_set = 8'h00;
        acc(0, 19, 2'd0, 0, 32'h0000_0002, "R8 read returns old cause", 8'h01);
        acc(0, 19, 2'd0, 0, 32'h0000_0001, "R8 same-cycle cause kept");
        acc(0, 19, 2'd0, 0, 32'h0000_0000, "R8 cleared by read");

        // R10 device-specific area, MSI-X off: starts at 20
        acc(0, 20, 2'd2, 0, 32'h5A3C_00FF, "R10 word at boundary");
        acc(0, 21, 2'd0, 0, 32'h0000_00FE, "R10 byte masked");

        // R9 MSI-X on
        msix_en = 1'b1;
        acc(0, 20, 2'd1, 0, 32'h0, "R9 cfg vector reset");
        acc(1, 20, 2'd1, 32'h0000_0007, 0, "R9 write");
        acc(0, 20, 2'd1, 0, 32'h0000_0007, "R9 cfg vector read");
        acc(1, 22, 2'd1, 32'h0000_0009, 0, "R9 write");
        check("R9 qvec_wr", qvec_wr, 1);
        check("R9 qvec_wdata", qvec_wdata, 9);
        acc(0, 22, 2'd1, 0, 32'h0000_0042, "R9 queue vector read");
        acc(0, 24, 2'd2, 0, 32'h5A3C_00FF, "R9 area starts at 24");
        acc(0, 25, 2'd1, 0, 32'h0000_01FE, "R10 half masked");
        acc(0, 21, 2'd0, 0, 32'h0, "R11 misaligned vector read");
        msix_en = 1'b0;
        acc(0, 20, 2'd2, 0, 32'h5A3C_00FF, "R9 boundary moves back");

        // R12 legacy driver detection
        feat32_acked = 1'b1;
        acc(1, 18, 2'd0, 32'h0000_0007, 0, "R12 write");
        check("R12 stays clear with ack", legacy_drv, 0);
        acc(1, 18, 2'd0, 32'h0000_0000, 0, "R12 write");
        feat32_acked = 1'b0;
        acc(1, 18, 2'd0, 32'h0000_0007, 0, "R12 write");
        check("R12 set without ack", legacy_drv, 1);
        acc(1, 18, 2'd0, 32'h0000_0000, 0, "R12 write");
        check("R12 cleared by status 0", legacy_drv, 0);
        check("R7 status cleared", dev_status, 0);

        repeat (3) @(negedge clk);
        check("R5 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule